// File: doc/BRIEF.md
# Weak Memory Ordering Window Tracker

This block sits beside the issue path of one hardware thread and works out, for each memory operation it accepts, which recent operations still in flight must be globally ordered before it under a weakly ordered memory model. Operations and fences arrive in program order, one per cycle. The block keeps a small circular window of the most recent memory operations. For every accepted item it returns, one cycle later, a bitmask over the window slots. A set bit means that the operation in that slot must become visible first.

The ordering sources are fence predecessor/successor bits, a TSO-style fence mode, acquire and release annotations in a weak (RCpc) and a strong (RCsc) flavour, stores to an address already in the window, load-reserve/store-conditional pairing, and address, data and control dependencies. The block also flags fence encodings outside the legal set and annotation combinations that are not allowed. It does not perform any access, does no store forwarding and does no checking across threads.

Top module: `mo_window_tracker`

## Requirements
- R1: `in_ready` is always high. Each item accepted on a rising edge produces an `out_valid` pulse on the next edge, with the mask and flags held in registers. Mask bit i refers to window slot i. Memory operations fill slots 0,1,...,7 in turn and wrap around, and `out_slot` reports the slot that was written. A fence takes no slot and gets an all-zero mask. Kind codes: 0 load, 1 store, 2 load-reserve, 3 store-conditional, 4 AMO, 5 fence.
- R2: A fence carries the bits `in_fence_bits` = {[3] earlier reads, [2] earlier writes, [1] later reads, [0] later writes}. An earlier load ends up ordered before every later load if a fence with bits [3] and [1] came between them, and before every later store if the fence had bits [3] and [0]. An earlier store follows the same rule with bit [2] in place of bit [3].
- R3: A fence with `in_fence_tso` set and all four bits clear orders each earlier load before every later memory operation, and each earlier store before later stores only.
- R4: The legal fence encodings (bits [3:0]) are 1010, 0101, 1101, 1011, 1111, and TSO mode with 0000. Any other encoding sets `out_fence_err` and has no effect on ordering.
- R5: An operation with `in_acq` set is ordered before every later memory operation.
- R6: An operation with `in_rel` set is ordered after every operation still live in the window.
- R7: If the operation in a window slot was annotated (acquire or release) with `in_rcsc` high, and the incoming operation is annotated with `in_rcsc` high as well, the two are ordered. Two RCpc-annotated operations are not ordered with each other by this rule.
- R8: `out_annot_err` is set for a plain load or load-reserve with release but without acquire, and for a plain store or store-conditional with acquire but without release. An AMO never raises it. The annotations are still applied as given.
- R9: An incoming store or AMO is ordered after every live slot with the same address. Two loads to the same address are not ordered by this rule.
- R10: An AMO counts as both a load and a store. A store-conditional is ordered after the most recent live load-reserve and then consumes the pairing. A second store-conditional has no partner.
- R11: An address or data dependency orders the incoming operation after the named slot. A control dependency orders the named slot only before the incoming operation if that operation is a store, and before all later stores. An address dependency also orders the named slot before all later stores.
- R12: When the window is full, the oldest slot is overwritten. It never appears in the new mask, and a dependency that names it is ignored.
- R13: Synchronous active-low reset empties the window, restarts slot allocation at 0 and clears the outputs. A dependency that names an empty slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Item offered |
| in_ready | output | 1 | Always high |
| in_kind | input | 3 | Item kind code |
| in_addr | input | ADDR_W | Address tag of a memory operation |
| in_fence_bits | input | 4 | Fence ordering bits |
| in_fence_tso | input | 1 | TSO-mode fence |
| in_acq | input | 1 | Acquire annotation |
| in_rel | input | 1 | Release annotation |
| in_rcsc | input | 1 | Annotation flavour is RCsc |
| in_adep_vld | input | 1 | Address dependency present |
| in_adep_idx | input | IDX_W | Slot of address dependency |
| in_ddep_vld | input | 1 | Data dependency present |
| in_ddep_idx | input | IDX_W | Slot of data dependency |
| in_cdep_vld | input | 1 | Control dependency present |
| in_cdep_idx | input | IDX_W | Slot of control dependency |
| out_valid | output | 1 | Result pulse |
| out_mask | output | DEPTH | Slots that must be ordered first |
| out_slot | output | IDX_W | Slot written by the operation |
| out_fence_err | output | 1 | Illegal fence encoding |
| out_annot_err | output | 1 | Illegal annotation combination |

## Verification
Mixed loads and stores on both sides of fences, each fence with a different bit set, show that each predecessor/successor pair is applied to the right class only. A legal TSO fence is followed by illegal encodings whose effect would be visible, which shows that rejected fences leave no trace. Runs that pair RCpc with RCsc annotations, loads with stores to one address, and two store-conditionals after a single load-reserve separate the annotation, same-address and pairing rules from each other. Dependency runs that end in a wrap-around check that control and address dependencies reach later stores, and that dependencies on retired or empty slots are dropped.

// File: rtl/mo_pkg.sv
// Shared encodings for the memory ordering window tracker.
// Assumes kind codes are fixed by the issue logic that feeds the block.
package mo_pkg;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_LR    = 3'd2,
        K_SC    = 3'd3,
        K_AMO   = 3'd4,
        K_FENCE = 3'd5
    } op_kind_e;

    // Per-slot bookkeeping kept alongside the address tag.
    typedef struct packed {
        logic vld;     // slot holds a live operation
        logic is_ld;   // reads memory
        logic is_st;   // writes memory
        logic rcsc;    // carries an RCsc annotation
        logic ord_ld;  // must precede every later load
        logic ord_st;  // must precede every later store
    } slot_meta_t;

endpackage

// File: rtl/mo_fence_decode.sv
// Fence decoder: checks a fence encoding against the legal set and turns it
// into four "earlier class before later class" enables. An illegal
// encoding gives all-zero enables. Assumes bits = {pr, pw, sr, sw}.
module mo_fence_decode (
    input  logic       is_fence,
    input  logic [3:0] bits,
    input  logic       tso,
    output logic       illegal,
    output logic       ld_to_ld,
    output logic       ld_to_st,
    output logic       st_to_ld,
    output logic       st_to_st
);
    logic legal;
    logic pr, pw, sr, sw;

    // Split the fence bits into named fields.
    always_comb begin
        {pr, pw, sr, sw} = bits;
    end

    // Legality check against the permitted encodings.
    always_comb begin
        if (tso) begin
            legal = (bits == 4'b0000);
        end else begin
            unique case (bits)
                4'b1010, 4'b0101, 4'b1101, 4'b1011, 4'b1111: legal = 1'b1;
                default:                                     legal = 1'b0;
            endcase
        end
        illegal = is_fence && !legal;
    end

    // Class-to-class enables; zero when the encoding is rejected.
    always_comb begin
        ld_to_ld = is_fence && legal && ((pr && sr) || tso);
        ld_to_st = is_fence && legal && ((pr && sw) || tso);
        st_to_ld = is_fence && legal && (pw && sr);
        st_to_st = is_fence && legal && ((pw && sw) || tso);
    end

    // R3: a TSO fence never orders stores before later loads.
    always_comb begin
        if (is_fence && tso)
            a_r3_tso_no_st_ld: assert (!st_to_ld);
    end

    // R4: a rejected fence enables nothing.
    always_comb begin
        if (illegal)
            a_r4_illegal_inert: assert (!(ld_to_ld || ld_to_st || st_to_ld || st_to_st));
    end

endmodule

// File: rtl/mo_order_eval.sv
// Ordering evaluator: for the incoming operation it decides, for each
// window slot, whether that slot must be ordered first. Purely
// combinational. Assumes the slot being overwritten (wr_slot) is
// already treated as retired.
module mo_order_eval #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  mo_pkg::slot_meta_t [DEPTH-1:0] meta,
    input  logic [DEPTH-1:0][ADDR_W-1:0]   addr,
    input  logic [IDX_W-1:0]               wr_slot,
    input  logic                           new_ld,
    input  logic                           new_st,
    input  logic                           new_rel,
    input  logic                           new_rcsc,
    input  logic [ADDR_W-1:0]              new_addr,
    input  logic [DEPTH-1:0]               adep_oh,
    input  logic [DEPTH-1:0]               ddep_oh,
    input  logic [DEPTH-1:0]               cdep_oh,
    input  logic [DEPTH-1:0]               pair_oh,
    output logic [DEPTH-1:0]               mask
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic live;
        logic by_fence, by_annot, by_addr, by_dep;

        // Decide whether slot i must precede the incoming operation.
        always_comb begin
            live     = meta[i].vld && (wr_slot != IDX_W'(i));
            by_fence = (new_ld && meta[i].ord_ld) || (new_st && meta[i].ord_st);
            by_annot = new_rel || (new_rcsc && meta[i].rcsc);
            by_addr  = new_st && (addr[i] == new_addr);
            by_dep   = adep_oh[i] || ddep_oh[i] || (cdep_oh[i] && new_st) || pair_oh[i];
            mask[i]  = live && (by_fence || by_annot || by_addr || by_dep);
        end
    end

endmodule

// File: rtl/mo_window_tracker.sv
// Weak memory ordering window tracker (top). Accepts one item per cycle
// in program order, keeps a circular window of DEPTH memory operations
// and returns a registered ordering mask one cycle after acceptance.
// Assumes dependency indices name window slots as reported in out_slot.
module mo_window_tracker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [3:0]        in_fence_bits,
    input  logic              in_fence_tso,
    input  logic              in_acq,
    input  logic              in_rel,
    input  logic              in_rcsc,
    input  logic              in_adep_vld,
    input  logic [IDX_W-1:0]  in_adep_idx,
    input  logic              in_ddep_vld,
    input  logic [IDX_W-1:0]  in_ddep_idx,
    input  logic              in_cdep_vld,
    input  logic [IDX_W-1:0]  in_cdep_idx,
    output logic              out_valid,
    output logic [DEPTH-1:0]  out_mask,
    output logic [IDX_W-1:0]  out_slot,
    output logic              out_fence_err,
    output logic              out_annot_err
);
    import mo_pkg::*;

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

    slot_meta_t [DEPTH-1:0]         meta_q;
    logic [DEPTH-1:0][ADDR_W-1:0]   addr_q;
    logic [IDX_W-1:0]               wr_q;
    logic                           lr_vld_q;
    logic [IDX_W-1:0]               lr_slot_q;

    logic       accept, is_mem, is_fence;
    logic       new_ld, new_st, new_rcsc, annot_bad;
    logic       f_illegal, f_ll, f_ls, f_sl, f_ss;
    logic [DEPTH-1:0] adep_oh, ddep_oh, cdep_oh, pair_oh, live_vec, mask_c;
    op_kind_e   kind;

    assign in_ready = 1'b1;

    // Classify the offered item.
    always_comb begin
        kind     = op_kind_e'(in_kind);
        accept   = in_valid && in_ready;
        is_fence = (kind == K_FENCE);
        is_mem   = (in_kind <= 3'd4);
        new_ld   = is_mem && (kind == K_LOAD || kind == K_LR || kind == K_AMO);
        new_st   = is_mem && (kind == K_STORE || kind == K_SC || kind == K_AMO);
        new_rcsc = is_mem && in_rcsc && (in_acq || in_rel);
        annot_bad = is_mem && ((new_ld && !new_st && in_rel && !in_acq) ||
                               (new_st && !new_ld && in_acq && !in_rel));
    end

    // Expand dependency indices and the reservation pairing to one-hot vectors.
    always_comb begin
        adep_oh = '0;
        ddep_oh = '0;
        cdep_oh = '0;
        pair_oh = '0;
        if (in_adep_vld) adep_oh[in_adep_idx] = 1'b1;
        if (in_ddep_vld) ddep_oh[in_ddep_idx] = 1'b1;
        if (in_cdep_vld) cdep_oh[in_cdep_idx] = 1'b1;
        if (kind == K_SC && lr_vld_q) pair_oh[lr_slot_q] = 1'b1;
    end

    // Slots that survive this write (the written slot retires).
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            live_vec[i] = meta_q[i].vld && (wr_q != IDX_W'(i));
    end

    mo_fence_decode u_fence (
        .is_fence (is_fence),
        .bits     (in_fence_bits),
        .tso      (in_fence_tso),
        .illegal  (f_illegal),
        .ld_to_ld (f_ll),
        .ld_to_st (f_ls),
        .st_to_ld (f_sl),
        .st_to_st (f_ss)
    );

    mo_order_eval #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_eval (
        .meta     (meta_q),
        .addr     (addr_q),
        .wr_slot  (wr_q),
        .new_ld   (new_ld),
        .new_st   (new_st),
        .new_rel  (is_mem && in_rel),
        .new_rcsc (new_rcsc),
        .new_addr (in_addr),
        .adep_oh  (adep_oh),
        .ddep_oh  (ddep_oh),
        .cdep_oh  (cdep_oh),
        .pair_oh  (pair_oh),
        .mask     (mask_c)
    );

    // Register the per-item result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_mask      <= '0;
            out_slot      <= '0;
            out_fence_err <= 1'b0;
            out_annot_err <= 1'b0;
        end else begin
            out_valid     <= accept;
            out_mask      <= (accept && is_mem) ? mask_c : '0;
            out_slot      <= wr_q;
            out_fence_err <= accept && f_illegal;
            out_annot_err <= accept && annot_bad;
        end
    end

    // Window state: fence marking, dependency marking and slot writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q    <= '0;
            addr_q    <= '0;
            wr_q      <= '0;
            lr_vld_q  <= 1'b0;
            lr_slot_q <= '0;
        end else if (accept && is_fence) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (meta_q[i].vld) begin
                    meta_q[i].ord_ld <= meta_q[i].ord_ld ||
                        (meta_q[i].is_ld && f_ll) || (meta_q[i].is_st && f_sl);
                    meta_q[i].ord_st <= meta_q[i].ord_st ||
                        (meta_q[i].is_ld && f_ls) || (meta_q[i].is_st && f_ss);
                end
            end
        end else if (accept && is_mem) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (live_vec[i] && (adep_oh[i] || cdep_oh[i]))
                    meta_q[i].ord_st <= 1'b1;
            end
            meta_q[wr_q] <= '{vld: 1'b1, is_ld: new_ld, is_st: new_st, rcsc: new_rcsc,
                              ord_ld: in_acq, ord_st: in_acq};
            addr_q[wr_q] <= in_addr;
            wr_q         <= (wr_q == LAST_SLOT) ? '0 : wr_q + 1'b1;
            if (kind == K_LR) begin
                lr_vld_q  <= 1'b1;
                lr_slot_q <= wr_q;
            end else if (kind == K_SC || (lr_vld_q && lr_slot_q == wr_q)) begin
                lr_vld_q  <= 1'b0;
            end
        end
    end

    // R1: every accepted item yields a result one cycle later.
    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no result without an accepted item.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: a fence takes no slot and reports an empty mask.
    a_r1_fence_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd5) |=> (out_mask == '0));

    // R8: annotation errors never come from fences.
    a_r8_no_annot_err_on_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd5) |=> !out_annot_err);

    // R4: the fence error flag comes only from fences.
    a_r4_ferr_only_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind != 3'd5) |=> !out_fence_err);

    // R6: a release covers exactly the slots that survive the write.
    a_r6_release_covers_live: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind <= 3'd4 && in_rel) |=> (out_mask == $past(live_vec)));

    // R12: the mask never names a retired or empty slot.
    a_r12_mask_within_live: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_mask & ~$past(live_vec)) == '0));

endmodule

// File: tb/mo_window_tracker_tb_top.sv
// Scoreboard bench: driver tasks push the expected result of each item,
// a monitor at the falling edge pops and compares.
module mo_window_tracker_tb_top;

    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int IW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [2:0] in_kind = '0;
    logic [AW-1:0] in_addr = '0;
    logic [3:0] in_fence_bits = '0;
    logic in_fence_tso = 1'b0, in_acq = 1'b0, in_rel = 1'b0, in_rcsc = 1'b0;
    logic in_adep_vld = 1'b0, in_ddep_vld = 1'b0, in_cdep_vld = 1'b0;
    logic [IW-1:0] in_adep_idx = '0, in_ddep_idx = '0, in_cdep_idx = '0;
    logic out_valid;
    logic [DEPTH-1:0] out_mask;
    logic [IW-1:0] out_slot;
    logic out_fence_err, out_annot_err;

    int checks = 0;
    int fails  = 0;
    int exp_slot = 0;

    typedef struct {
        logic [7:0] mask;
        int         slot;
        bit         chk_slot;
        logic       ferr;
        logic       aerr;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    mo_window_tracker #(.DEPTH(DEPTH), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_addr(in_addr), .in_fence_bits(in_fence_bits),
        .in_fence_tso(in_fence_tso), .in_acq(in_acq), .in_rel(in_rel),
        .in_rcsc(in_rcsc), .in_adep_vld(in_adep_vld), .in_adep_idx(in_adep_idx),
        .in_ddep_vld(in_ddep_vld), .in_ddep_idx(in_ddep_idx),
        .in_cdep_vld(in_cdep_vld), .in_cdep_idx(in_cdep_idx),
        .out_valid(out_valid), .out_mask(out_mask), .out_slot(out_slot),
        .out_fence_err(out_fence_err), .out_annot_err(out_annot_err));

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid === 1'b1) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(out_mask == e.mask, e.tag, "mask", int'(out_mask), int'(e.mask));
                check(out_fence_err == e.ferr, e.tag, "fence_err",
                      int'(out_fence_err), int'(e.ferr));
                check(out_annot_err == e.aerr, e.tag, "annot_err",
                      int'(out_annot_err), int'(e.aerr));
                if (e.chk_slot)
                    check(int'(out_slot) == e.slot, e.tag, "slot", int'(out_slot), e.slot);
            end
        end
    end

    task automatic issue(input exp_t e);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        sb_q.push_back(e);
    endtask

    task automatic clear_inputs();
        in_fence_bits = '0; in_fence_tso = 0; in_acq = 0; in_rel = 0; in_rcsc = 0;
        in_adep_vld = 0; in_ddep_vld = 0; in_cdep_vld = 0;
        in_adep_idx = '0; in_ddep_idx = '0; in_cdep_idx = '0;
    endtask

    // Memory operation with annotations.
    task automatic mem(input logic [2:0] k, input int a, input logic acq, rel, rcsc,
                       input logic [7:0] emask, input logic eaerr, input string tag);
        exp_t e;
        e = '{mask: emask, slot: exp_slot, chk_slot: 1'b1, ferr: 1'b0, aerr: eaerr, tag: tag};
        issue(e);
        clear_inputs();
        in_kind = k; in_addr = AW'(a); in_acq = acq; in_rel = rel; in_rcsc = rcsc;
        exp_slot = (exp_slot + 1) % DEPTH;
    endtask

    // Memory operation with dependencies.
    task automatic dep(input logic [2:0] k, input int a,
                       input logic av, input int ai, input logic dv, input int di,
                       input logic cv, input int ci,
                       input logic [7:0] emask, input string tag);
        exp_t e;
        e = '{mask: emask, slot: exp_slot, chk_slot: 1'b1, ferr: 1'b0, aerr: 1'b0, tag: tag};
        issue(e);
        clear_inputs();
        in_kind = k; in_addr = AW'(a);
        in_adep_vld = av; in_adep_idx = IW'(ai);
        in_ddep_vld = dv; in_ddep_idx = IW'(di);
        in_cdep_vld = cv; in_cdep_idx = IW'(ci);
        exp_slot = (exp_slot + 1) % DEPTH;
    endtask

    task automatic fence(input logic [3:0] b, input logic tso, input logic eferr,
                         input string tag);
        exp_t e;
        e = '{mask: 8'h00, slot: 0, chk_slot: 1'b0, ferr: eferr, aerr: 1'b0, tag: tag};
        issue(e);
        clear_inputs();
        in_kind = 3'd5; in_fence_bits = b; in_fence_tso = tso;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_slot = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "timeout", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: outputs clear under reset.
        check(out_valid == 1'b0, "R13", "reset out_valid", int'(out_valid), 0);
        check(out_mask == '0, "R13", "reset out_mask", int'(out_mask), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: fence bit pairs, per class.
        mem(3'd0, 1, 0, 0, 0, 8'h00, 0, "R1 load s0");
        mem(3'd1, 2, 0, 0, 0, 8'h00, 0, "R1 store s1");
        fence(4'b1010, 0, 0, "R2 fence rr");
        mem(3'd0, 3, 0, 0, 0, 8'h01, 0, "R2 load after rr");
        mem(3'd1, 4, 0, 0, 0, 8'h00, 0, "R2 store not ordered by rr");
        fence(4'b0101, 0, 0, "R2 fence ww");
        mem(3'd1, 5, 0, 0, 0, 8'h0A, 0, "R2 store after ww");
        mem(3'd0, 6, 0, 0, 0, 8'h01, 0, "R2 load after ww");
        fence(4'b1101, 0, 0, "R2 fence rw_w");
        mem(3'd1, 7, 0, 0, 0, 8'h3F, 0, "R2 store after rw_w");

        // R3/R4: TSO fence, then rejected encodings that must not act.
        do_reset();
        mem(3'd0, 1, 0, 0, 0, 8'h00, 0, "R13 slot restarts");
        mem(3'd1, 2, 0, 0, 0, 8'h00, 0, "R3 store s1");
        fence(4'b0000, 1, 0, "R3 tso fence");
        mem(3'd0, 3, 0, 0, 0, 8'h01, 0, "R3 load after tso");
        mem(3'd1, 4, 0, 0, 0, 8'h03, 0, "R3 store after tso");
        fence(4'b1010, 1, 1, "R4 tso with bits");
        fence(4'b0011, 0, 1, "R4 bad encoding");
        mem(3'd0, 5, 0, 0, 0, 8'h01, 0, "R4 illegal fence inert");
        mem(3'd1, 6, 0, 0, 0, 8'h03, 0, "R4 illegal fence inert st");

        // R5/R6/R8: acquire, release, annotation errors.
        do_reset();
        mem(3'd0, 1, 1, 0, 0, 8'h00, 0, "R5 acquire load");
        mem(3'd1, 2, 0, 0, 0, 8'h01, 0, "R5 store after acquire");
        mem(3'd0, 3, 0, 0, 0, 8'h01, 0, "R5 load after acquire");
        mem(3'd1, 4, 0, 1, 0, 8'h07, 0, "R6 release store");
        mem(3'd0, 5, 0, 1, 0, 8'h0F, 1, "R8 load release only");
        mem(3'd1, 6, 1, 0, 0, 8'h01, 1, "R8 store acquire only");
        mem(3'd0, 7, 0, 0, 0, 8'h21, 0, "R8 annotations still applied");
        mem(3'd4, 8, 0, 1, 0, 8'h7F, 0, "R8 amo release no error");

        // R7: RCpc pair unordered, RCsc pair ordered.
        do_reset();
        mem(3'd1, 1, 0, 1, 0, 8'h00, 0, "R7 rcpc release");
        mem(3'd0, 2, 1, 0, 0, 8'h00, 0, "R7 rcpc acquire unordered");
        mem(3'd1, 3, 0, 1, 1, 8'h03, 0, "R7 rcsc release");
        mem(3'd0, 4, 1, 0, 1, 8'h06, 0, "R7 rcsc acquire ordered");

        // R9/R10/R12: same address, reservation pairing, AMO, wrap.
        do_reset();
        mem(3'd0, 7, 0, 0, 0, 8'h00, 0, "R9 load a7");
        mem(3'd0, 7, 0, 0, 0, 8'h00, 0, "R9 load-load same addr");
        mem(3'd1, 7, 0, 0, 0, 8'h03, 0, "R9 store same addr");
        mem(3'd1, 8, 0, 0, 0, 8'h00, 0, "R9 other addr");
        mem(3'd2, 9, 0, 0, 0, 8'h00, 0, "R10 load-reserve");
        mem(3'd1, 10, 0, 0, 0, 8'h00, 0, "R10 plain store");
        mem(3'd3, 11, 0, 0, 0, 8'h10, 0, "R10 sc pairs lr");
        mem(3'd3, 12, 0, 0, 0, 8'h00, 0, "R10 second sc unpaired");
        mem(3'd4, 7, 0, 0, 0, 8'h06, 0, "R12 amo wraps, oldest retired");
        fence(4'b1010, 0, 0, "R10 fence rr");
        mem(3'd0, 13, 0, 0, 0, 8'h11, 0, "R10 amo counts as load");

        // R11/R12: dependencies.
        do_reset();
        mem(3'd0, 1, 0, 0, 0, 8'h00, 0, "R11 load s0");
        mem(3'd0, 2, 0, 0, 0, 8'h00, 0, "R11 load s1");
        mem(3'd0, 3, 0, 0, 0, 8'h00, 0, "R11 load s2");
        dep(3'd0, 4, 1, 0, 0, 0, 0, 0, 8'h01, "R11 addr dep");
        dep(3'd0, 5, 0, 0, 1, 1, 0, 0, 8'h02, "R11 data dep");
        dep(3'd0, 6, 0, 0, 0, 0, 1, 2, 8'h00, "R11 ctrl dep load");
        dep(3'd1, 7, 0, 0, 0, 0, 0, 0, 8'h05, "R11 later store");
        dep(3'd1, 8, 0, 0, 1, 1, 1, 4, 8'h17, "R11 data+ctrl store");
        dep(3'd0, 9, 1, 0, 0, 0, 0, 0, 8'h00, "R12 dep on retired slot");

        // R13: dependency on an empty slot after reset.
        do_reset();
        dep(3'd0, 1, 1, 3, 0, 0, 0, 0, 8'h00, "R13 dep on empty slot");

        @(posedge clk);
        #1 in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "R1", "pending results", sb_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule